// File: doc/BRIEF.md
# Converter Serial Output Shifter

This block sends a converter's result word out on one serial data line, most significant bit first. It holds the word in a shift register that is loaded whenever a conversion completes, and every data clock moves the register one place toward the output, with a zero entering at the bottom. A serial read therefore consumes the word, and a second read returns zeros until the next load.

Two clocking modes exist. In internal-clock mode the block produces its own data clock: when a conversion begins it emits exactly one word's worth of clock pulses, presenting the previous conversion's result, then parks the clock low. In external-clock mode a clock arriving from outside is passed through a two-flop synchronizer and an edge detector, and each rising edge shifts the register. What such a read returns depends on the conversion state. While a conversion is running it returns the previous result. Once the conversion has finished it returns the new result. With chip-select low, a rising read/convert line restarts an external-clock read from the stored result. In internal-clock mode that event is ignored.

All control inputs are synchronous to the system clock except the external data clock. Edge-accurate analog timing is not modelled.

Top module: `serial_result_shifter`

## Requirements
- R1: After reset, serialOut and dataClkOut are both 0.
- R2: When convIdle goes from 0 to 1 (conversion complete), the register loads resultIn, and serialOut shows resultIn bit 15 from the next cycle.
- R3: In internal-clock mode (intClkMode = 1), a fall of convIdle (conversion start) produces exactly 16 dataClkOut pulses. Each pulse is high for HALF_PERIOD cycles and low for HALF_PERIOD cycles between pulses. After the burst, dataClkOut stays low.
- R4: The bits present on serialOut at each rising dataClkOut of an internal burst are the word loaded at the previous completion, bit 15 first.
- R5: In external-clock mode (intClkMode = 0), each synchronized rising edge of extDataClk shifts the register by one place, and dataClkOut stays 0.
- R6: In external-clock mode, a read made while convIdle is 0 returns the previous result. A read made after completion returns the new result.
- R7: Each shift moves a 0 into bit 0. Once 16 shifts have drained the register, further shifts leave serialOut at 0.
- R8: With csN = 0, a 0-to-1 change of rdConvN reloads the register from resultIn in external-clock mode. In internal-clock mode the same change has no effect.
- R9: If a load and an external shift edge fall in the same cycle, the load wins and no shift happens in that cycle.
- R10: In internal-clock mode, extDataClk edges do not shift the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| intClkMode | input | 1 | 1 = internal data clock, 0 = external data clock |
| extDataClk | input | 1 | Asynchronous external data clock |
| csN | input | 1 | Active-low chip select |
| rdConvN | input | 1 | Read (1) / convert (0) control |
| convIdle | input | 1 | 1 when no conversion is running |
| resultIn | input | DATA_W | Latest conversion result |
| serialOut | output | 1 | Serial data, MSB first |
| dataClkOut | output | 1 | Generated data clock in internal mode |

## Verification
A completion load and a synchronized external shift edge can both be due in the same cycle. The bench provokes this in external-clock mode while a conversion is running. It raises extDataClk, waits until the synchronizer is one edge from producing its shift, and then raises convIdle so that both events arrive on the same clock edge. It judges the outcome by checking that serialOut shows the new word's MSB. It then reads all 16 bits back through the external clock: a word that was shifted once would come back misaligned.

// File: rtl/sos_pkg.sv
package sos_pkg;
  typedef struct packed {
    logic load;   // copy resultIn into the shift register
    logic shift;  // move one place toward serialOut
  } shift_strobe_t;
endpackage

// File: rtl/sos_ctrl.sv
module sos_ctrl
  import sos_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HALF_PERIOD = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          intClkMode,
  input  logic          extDataClk,
  input  logic          csN,
  input  logic          rdConvN,
  input  logic          convIdle,
  output shift_strobe_t strb,
  output logic          dataClkOut
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int PH_W  = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(DATA_W - 1);
  localparam logic [PH_W-1:0]  LAST_PHASE = PH_W'(HALF_PERIOD - 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic extPrev, idleQ, rcQ;
  logic burstActive, clkHigh;
  logic [PH_W-1:0]  phaseCnt;
  logic [CNT_W-1:0] bitCnt;

  logic extRise, convDone, convStart, reloadReq, burstShift, extShift;

  // synchronizer and edge history for the asynchronous data clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg <= '0;
      extPrev <= 1'b0;
      idleQ   <= 1'b1;
      rcQ     <= 1'b1;
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], extDataClk};
      extPrev <= syncReg[SYNC_STAGES-1];
      idleQ   <= convIdle;
      rcQ     <= rdConvN;
    end
  end

  assign extRise    = syncReg[SYNC_STAGES-1] & ~extPrev;
  assign convDone   = convIdle & ~idleQ;
  assign convStart  = ~convIdle & idleQ;
  assign reloadReq  = ~intClkMode & ~csN & rdConvN & ~rcQ;
  assign burstShift = burstActive & clkHigh & (phaseCnt == LAST_PHASE);
  assign extShift   = ~intClkMode & extRise;

  // internal burst generator: one high and one low phase per bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      clkHigh     <= 1'b0;
      phaseCnt    <= '0;
      bitCnt      <= '0;
    end else if (!burstActive) begin
      if (convStart && intClkMode) begin
        burstActive <= 1'b1;
        clkHigh     <= 1'b1;
        phaseCnt    <= '0;
        bitCnt      <= '0;
      end
    end else if (phaseCnt == LAST_PHASE) begin
      phaseCnt <= '0;
      if (clkHigh) begin
        clkHigh <= 1'b0;
        if (bitCnt == LAST_BIT) burstActive <= 1'b0;
        else                    bitCnt <= bitCnt + 1'b1;
      end else begin
        clkHigh <= 1'b1;
      end
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    strb.load  = convDone | reloadReq;
    strb.shift = (burstShift | extShift) & ~strb.load;
  end

  assign dataClkOut = clkHigh;
endmodule

// File: rtl/sos_datapath.sv
module sos_datapath
  import sos_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  shift_strobe_t     strb,
  input  logic [DATA_W-1:0] resultIn,
  output logic [DATA_W-1:0] shiftWord,
  output logic              serialOut
);
  always_ff @(posedge clk) begin
    if (!rstN)           shiftWord <= '0;
    else if (strb.load)  shiftWord <= resultIn;
    else if (strb.shift) shiftWord <= {shiftWord[DATA_W-2:0], 1'b0};
  end

  assign serialOut = shiftWord[DATA_W-1];
endmodule

// File: rtl/serial_result_shifter.sv
module serial_result_shifter
  import sos_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HALF_PERIOD = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intClkMode,
  input  logic              extDataClk,
  input  logic              csN,
  input  logic              rdConvN,
  input  logic              convIdle,
  input  logic [DATA_W-1:0] resultIn,
  output logic              serialOut,
  output logic              dataClkOut
);
  shift_strobe_t     strb;
  logic [DATA_W-1:0] shiftWord;

  sos_ctrl #(
    .DATA_W(DATA_W), .HALF_PERIOD(HALF_PERIOD), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .intClkMode(intClkMode), .extDataClk(extDataClk),
    .csN(csN), .rdConvN(rdConvN), .convIdle(convIdle),
    .strb(strb), .dataClkOut(dataClkOut)
  );

  sos_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .resultIn(resultIn),
    .shiftWord(shiftWord), .serialOut(serialOut)
  );
endmodule

// File: rtl/sos_checker.sv
module sos_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              intClkMode,
  input logic              convIdle,
  input logic [DATA_W-1:0] resultIn,
  input logic              dataClkOut,
  input logic [DATA_W-1:0] shiftWord,
  input logic              strbLoad,
  input logic              strbShift
);
  logic idlePrev, clkPrev;
  int   pulseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idlePrev <= 1'b1;
      clkPrev  <= 1'b0;
      pulseCnt <= 0;
    end else begin
      idlePrev <= convIdle;
      clkPrev  <= dataClkOut;
      if (idlePrev && !convIdle)        pulseCnt <= 0;
      else if (dataClkOut && !clkPrev)  pulseCnt <= pulseCnt + 1;
    end
  end

  // R2: a load places resultIn into the register
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    strbLoad |=> shiftWord == $past(resultIn));

  // R7: a shift moves one place with zero fill
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    strbShift |=> shiftWord == {$past(shiftWord[DATA_W-2:0]), 1'b0});

  // R5: no generated clock in external-clock mode
  p_ext_no_clk_r5: assert property (@(posedge clk) disable iff (!rstN)
    dataClkOut |-> intClkMode);

  // R3: a burst never exceeds one word of pulses
  p_pulse_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= DATA_W);

  // R10: in internal mode shifts only come from the generated clock
  p_int_ignores_ext_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strbShift && intClkMode) |-> dataClkOut);
endmodule

bind serial_result_shifter sos_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .intClkMode(intClkMode), .convIdle(convIdle),
  .resultIn(resultIn), .dataClkOut(dataClkOut), .shiftWord(shiftWord),
  .strbLoad(strb.load), .strbShift(strb.shift)
);

// File: tb/serial_result_shifter_test.sv
module serial_result_shifter_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intClkMode = 1'b0;
  logic extDataClk = 1'b0;
  logic csN = 1'b1;
  logic rdConvN = 1'b1;
  logic convIdle = 1'b1;
  logic [W-1:0] resultIn = '0;
  logic serialOut, dataClkOut;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  serial_result_shifter uut (
    .clk(clk), .rstN(rstN), .intClkMode(intClkMode), .extDataClk(extDataClk),
    .csN(csN), .rdConvN(rdConvN), .convIdle(convIdle), .resultIn(resultIn),
    .serialOut(serialOut), .dataClkOut(dataClkOut)
  );

  // {internal mode, previous result, new result}
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 16'hA5C3, 16'h0F0F},
    {1'b0, 16'h1234, 16'hFEDC},
    {1'b1, 16'hFFFF, 16'h0001},
    {1'b0, 16'h8000, 16'h7FFF},
    {1'b1, 16'h0000, 16'hFFFF},
    {1'b0, 16'h5A5A, 16'hC3A5}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startConv();
    @(negedge clk) convIdle = 1'b0;
  endtask

  task automatic complete(input logic [W-1:0] val);
    @(negedge clk);
    resultIn = val;
    convIdle = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic extPulse();
    @(negedge clk) extDataClk = 1'b1;
    repeat (4) @(negedge clk);
    extDataClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic readExt(output logic [W-1:0] word);
    word = '0;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      word = {word[W-2:0], serialOut};
      extPulse();
    end
  endtask

  // starts a conversion and records the internal burst
  task automatic captureBurst(output logic [W-1:0] word, output int rises,
                              output int badWidth);
    logic prevClk = 1'b0;
    int   hiCnt = 0;
    word = '0; rises = 0; badWidth = 0;
    @(negedge clk) convIdle = 1'b0;
    for (int c = 0; c < 130; c++) begin
      @(negedge clk);
      if (dataClkOut && !prevClk) begin
        rises++;
        word = {word[W-2:0], serialOut};
        hiCnt = 0;
      end
      if (dataClkOut) hiCnt++;
      if (!dataClkOut && prevClk && hiCnt != 2) badWidth++;
      prevClk = dataClkOut;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [W-1:0] word;
    int rises, badWidth;
    logic held;

    repeat (3) @(negedge clk);
    check(serialOut == 1'b0, "R1 serialOut after reset", 32'(serialOut), 0);
    check(dataClkOut == 1'b0, "R1 dataClkOut after reset", 32'(dataClkOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic mode;
      logic [W-1:0] prevW, nextW;
      {mode, prevW, nextW} = VEC[v];
      intClkMode = mode;
      startConv();
      repeat (80) @(negedge clk);
      complete(prevW);
      check(serialOut == prevW[W-1], "R2 MSB after load", 32'(serialOut), 32'(prevW[W-1]));
      if (mode) begin
        captureBurst(word, rises, badWidth);
        check(word == prevW, "R4 burst carries previous result", 32'(word), 32'(prevW));
        check(rises == W, "R3 burst pulse count", 32'(rises), W);
        check(badWidth == 0, "R3 pulse high width", 32'(badWidth), 0);
        check(dataClkOut == 1'b0, "R3 clock parked low", 32'(dataClkOut), 0);
        complete(nextW);
        check(serialOut == nextW[W-1], "R2 MSB of new result", 32'(serialOut), 32'(nextW[W-1]));
      end else begin
        startConv();
        repeat (2) @(negedge clk);
        readExt(word);
        check(word == prevW, "R6 read during conversion", 32'(word), 32'(prevW));
        check(dataClkOut == 1'b0, "R5 no generated clock", 32'(dataClkOut), 0);
        complete(nextW);
        readExt(word);
        check(word == nextW, "R6 read after completion", 32'(word), 32'(nextW));
      end
    end

    // R7: drained register keeps returning zero
    extPulse();
    check(serialOut == 1'b0, "R7 drained after 16 shifts", 32'(serialOut), 0);
    readExt(word);
    check(word == '0, "R7 second read all zero", 32'(word), 0);

    // R5: a single external edge shifts by one with zero fill
    startConv();
    repeat (4) @(negedge clk);
    complete(16'h4000);
    check(serialOut == 1'b0, "R5 MSB before shift", 32'(serialOut), 0);
    extPulse();
    check(serialOut == 1'b1, "R5 one shift per edge", 32'(serialOut), 1);

    // R8 external: rising rdConvN with csN low reloads from resultIn
    readExt(word);
    resultIn = 16'hC3A5;
    csN = 1'b0;
    @(negedge clk) rdConvN = 1'b0;
    @(negedge clk) rdConvN = 1'b1;
    repeat (2) @(negedge clk);
    check(serialOut == 1'b1, "R8 reload shows MSB", 32'(serialOut), 1);
    readExt(word);
    check(word == 16'hC3A5, "R8 reload full word", 32'(word), 32'hC3A5);

    // R8 internal: same event ignored
    intClkMode = 1'b1;
    @(negedge clk) rdConvN = 1'b0;
    @(negedge clk) rdConvN = 1'b1;
    repeat (2) @(negedge clk);
    check(serialOut == 1'b0, "R8 ignored in internal mode", 32'(serialOut), 0);
    csN = 1'b1;

    // R10: external edges ignored in internal mode
    startConv();
    repeat (80) @(negedge clk);
    complete(16'h8000);
    held = serialOut;
    extPulse();
    extPulse();
    check(serialOut == 1'b1 && held == 1'b1, "R10 ext clock ignored", 32'(serialOut), 1);

    // R9: completion load and external shift on the same edge
    intClkMode = 1'b0;
    repeat (2) @(negedge clk);
    startConv();
    repeat (4) @(negedge clk);
    resultIn = 16'hA000;
    extDataClk = 1'b1;
    repeat (2) @(negedge clk);
    convIdle = 1'b1;
    repeat (3) @(negedge clk);
    extDataClk = 1'b0;
    repeat (4) @(negedge clk);
    check(serialOut == 1'b1, "R9 load wins MSB", 32'(serialOut), 1);
    readExt(word);
    check(word == 16'hA000, "R9 load wins full word", 32'(word), 32'hA000);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule